// File: doc/BRIEF.md
# Start-of-Active-Video FIFO Load Strobe

This block sits on a 10-bit parallel video word stream that is clocked by the pixel clock. It watches the stream for timing reference sequences that mark the start of active video on a line. For each one it finds, it emits an active-low strobe. Downstream line FIFOs use that strobe as their write reset, which supports auto-phasing and line synchronization.

The video words leave the block through a fixed-depth pipeline. The strobe travels through the same pipeline, so the strobe is low on exactly the edge where the reference's final (XYZ) word sits on the output bus. The next output word is therefore the first active sample of the line.

Detection runs only while the SMPTE-mode input is high. When that input is low, the words still pass through the pipeline but the strobe stays high. An end-of-active-video reference is recognised only so that it can be rejected.

Top module: `sav_fifo_strobe`

## Requirements
- R1: While reset is asserted and after its release, until a qualifying sequence has passed, `fifo_ld_n` is 1 and `dout` is 0.
- R2: `dout` carries `din` delayed by exactly PIPE_DEPTH clock cycles (default 2), in every mode.
- R3: The input words 3FF, 000, 000, XYZ on consecutive cycles, with XYZ bit 6 equal to 0 and `smpte_en` high for all four words, drive `fifo_ld_n` low for exactly one cycle. That cycle is the one in which XYZ is on `dout`.
- R4: The word on `dout` in the cycle after the strobe is the input word that followed XYZ, which is the first active sample.
- R5: When XYZ has bit 6 equal to 1 (end of active video), `fifo_ld_n` stays high.
- R6: A sequence that arrives while `smpte_en` is 0 leaves `fifo_ld_n` high.
- R7: A preamble broken by any other word restarts the search. A 3FF that breaks the preamble starts a new one, so 3FF, 000, 3FF, 000, 000, SAV gives one strobe, and 3FF, 000, 155, 000, 000, SAV gives none.
- R8: Repeated 3FF words before the two zero words still form a valid preamble (3FF, 3FF, 000, 000, SAV gives one strobe).
- R9: Two complete sequences sent back to back each give their own strobe, four cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smpte_en | input | 1 | High selects SMPTE mode and enables detection |
| din | input | 10 | Incoming video word |
| fifo_ld_n | output | 1 | Active-low FIFO load strobe, one cycle wide |
| dout | output | 10 | Video word delayed to align with the strobe |

## Verification
The stimulus consists of these streams:
- A clean start-of-active-video sequence followed by active samples. This checks both where the strobe lands and which word follows it.
- The same preamble ending in an end-of-active-video word, and the same sequence with SMPTE mode off. These separate the H-bit decode from the mode gate.
- Preambles broken by a stray 3FF or by an unrelated word, and a preamble with a doubled 3FF. These tell a correct restart apart from a detector that only counts words or one that never resynchronises.
- Two sequences sent back to back. This shows that the search re-arms at once after an XYZ word.

// File: rtl/sav_pkg.sv
package sav_pkg;

  // Progress through the three-word preamble of a timing reference
  typedef enum logic [1:0] {
    TRS_IDLE = 2'd0,  // no preamble word seen
    TRS_ONES = 2'd1,  // all-ones word seen
    TRS_Z1   = 2'd2,  // all-ones, zero seen
    TRS_Z2   = 2'd3   // all-ones, zero, zero seen: next word is XYZ
  } trs_state_e;

  // Bit of the XYZ word that separates end (1) from start (0) of active video
  localparam int unsigned XYZ_H_BIT = 6;

endpackage

// File: rtl/sav_rst_sync.sv
module sav_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sav_trs_matcher.sv
module sav_trs_matcher
  import sav_pkg::*;
#(
  parameter int unsigned DATA_W = 10,
  parameter int unsigned H_BIT  = XYZ_H_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic              sav_hit
);

  localparam logic [DATA_W-1:0] WORD_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] WORD_ZERO = {DATA_W{1'b0}};

  trs_state_e state_q;
  trs_state_e state_d;
  logic       is_ones;
  logic       is_zero;

  assign is_ones = (din == WORD_ONES);
  assign is_zero = (din == WORD_ZERO);

  always_comb begin
    state_d = TRS_IDLE;
    sav_hit = 1'b0;
    if (en) begin
      unique case (state_q)
        TRS_IDLE: state_d = is_ones ? TRS_ONES : TRS_IDLE;
        TRS_ONES: begin
          if (is_zero)      state_d = TRS_Z1;
          else if (is_ones) state_d = TRS_ONES;
          else              state_d = TRS_IDLE;
        end
        TRS_Z1: begin
          if (is_zero)      state_d = TRS_Z2;
          else if (is_ones) state_d = TRS_ONES;
          else              state_d = TRS_IDLE;
        end
        TRS_Z2: begin
          // current word is XYZ
          sav_hit = ~din[H_BIT];
          state_d = is_ones ? TRS_ONES : TRS_IDLE;
        end
        default: state_d = TRS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TRS_IDLE;
    else        state_q <= state_d;
  end

  // R6
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !sav_hit);

  // R7
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sav_hit |-> ($past(din, 1) == WORD_ZERO && $past(din, 2) == WORD_ZERO &&
                 $past(din, 3) == WORD_ONES));

  // R5
  sav_h_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sav_hit |-> (din[H_BIT] == 1'b0));

endmodule

// File: rtl/sav_align_pipe.sv
module sav_align_pipe #(
  parameter int unsigned WIDTH = 11,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_word,
  output logic [WIDTH-1:0] out_word
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] stage_d [DEPTH];

  assign stage_d[0] = in_word;

  for (genvar g = 1; g < DEPTH; g++) begin : g_link
    assign stage_d[g] = stage_q[g-1];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign out_word = stage_q[LAST];

endmodule

// File: rtl/sav_fifo_strobe.sv
module sav_fifo_strobe
  import sav_pkg::*;
#(
  parameter int unsigned DATA_W     = 10,
  parameter int unsigned PIPE_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smpte_en,
  input  logic [DATA_W-1:0] din,
  output logic              fifo_ld_n,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned PIPE_W = DATA_W + 1;

  logic              rst_n_int;
  logic              sav_hit;
  logic [PIPE_W-1:0] pipe_in;
  logic [PIPE_W-1:0] pipe_out;

  sav_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sav_trs_matcher #(
    .DATA_W (DATA_W),
    .H_BIT  (XYZ_H_BIT)
  ) u_matcher (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (smpte_en),
    .din     (din),
    .sav_hit (sav_hit)
  );

  assign pipe_in = {sav_hit, din};

  sav_align_pipe #(
    .WIDTH (PIPE_W),
    .DEPTH (PIPE_DEPTH)
  ) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_word  (pipe_in),
    .out_word (pipe_out)
  );

  assign fifo_ld_n = ~pipe_out[DATA_W];
  assign dout      = pipe_out[DATA_W-1:0];

  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !fifo_ld_n |=> fifo_ld_n);

  // R3
  strobe_on_sav_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !fifo_ld_n |-> (dout[XYZ_H_BIT] == 1'b0));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n_int |-> (fifo_ld_n && dout == '0));

endmodule

// File: tb/sav_fifo_strobe_bench.sv
module sav_fifo_strobe_bench;

  localparam int DW = 10;
  localparam int PD = 2;

  typedef struct {
    logic          ld_n;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smpte_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic          fifo_ld_n;
  logic [DW-1:0] dout;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;
  exp_t exp_q[$];

  logic [DW-1:0] hw [3];
  logic          hen [3];

  always #10 clk = ~clk;

  sav_fifo_strobe #(.DATA_W(DW), .PIPE_DEPTH(PD)) u_sav_fifo_strobe (
    .clk (clk), .rst_n (rst_n), .smpte_en (smpte_en),
    .din (din), .fifo_ld_n (fifo_ld_n), .dout (dout)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: one word per cycle, expected result from a sliding window model
  task automatic drive(input logic [DW-1:0] w, input logic en, input string tag);
    exp_t e;
    bit   pulse;
    @(negedge clk);
    din = w;
    smpte_en = en;
    pulse = en && hen[0] && hen[1] && hen[2] &&
            hw[2] == 10'h3FF && hw[1] == 10'h000 && hw[0] == 10'h000 && !w[6];
    e.ld_n = !pulse;
    e.data = w;
    e.tag  = tag;
    exp_q.push_back(e);
    hw[2] = hw[1]; hw[1] = hw[0]; hw[0] = w;
    hen[2] = hen[1]; hen[1] = hen[0]; hen[0] = en;
  endtask

  // monitor: item driven at negedge n is visible at negedge n+PD
  always @(negedge clk) begin
    #1;
    if (mon_on && exp_q.size() == PD + 1) begin
      exp_t e;
      e = exp_q.pop_front();
      check(fifo_ld_n == e.ld_n, e.tag, "fifo_ld_n", fifo_ld_n, e.ld_n);
      check(dout == e.data, "R2", "dout", dout, e.data);
    end
  end

  task automatic preamble(input logic en, input string tag);
    drive(10'h3FF, en, tag);
    drive(10'h000, en, tag);
    drive(10'h000, en, tag);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin hw[i] = 10'h155; hen[i] = 1'b0; end
    repeat (3) @(negedge clk);
    #1;
    check(fifo_ld_n == 1'b1, "R1", "fifo_ld_n in reset", fifo_ld_n, 1);
    check(dout == '0, "R1", "dout in reset", dout, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(fifo_ld_n == 1'b1, "R1", "fifo_ld_n after release", fifo_ld_n, 1);
    check(dout == '0, "R1", "dout after release", dout, 0);
    mon_on = 1'b1;

    drive(10'h200, 1'b1, "R2");
    drive(10'h040, 1'b1, "R2");
    // R3 / R4: SAV then active samples
    preamble(1'b1, "R3");
    drive(10'h200, 1'b1, "R3");
    drive(10'h123, 1'b1, "R4");
    drive(10'h0AB, 1'b1, "R4");
    // R5: EAV
    preamble(1'b1, "R5");
    drive(10'h274, 1'b1, "R5");
    drive(10'h050, 1'b1, "R5");
    // R6: mode off
    preamble(1'b0, "R6");
    drive(10'h200, 1'b0, "R6");
    drive(10'h111, 1'b0, "R6");
    drive(10'h040, 1'b1, "R6");
    // R7: stray 3FF restarts
    drive(10'h3FF, 1'b1, "R7");
    drive(10'h000, 1'b1, "R7");
    preamble(1'b1, "R7");
    drive(10'h2AC, 1'b1, "R7");
    drive(10'h080, 1'b1, "R7");
    // R7: unrelated word breaks
    drive(10'h3FF, 1'b1, "R7");
    drive(10'h000, 1'b1, "R7");
    drive(10'h155, 1'b1, "R7");
    drive(10'h000, 1'b1, "R7");
    drive(10'h000, 1'b1, "R7");
    drive(10'h200, 1'b1, "R7");
    drive(10'h080, 1'b1, "R7");
    // R8: doubled all-ones word
    drive(10'h3FF, 1'b1, "R8");
    preamble(1'b1, "R8");
    drive(10'h31C, 1'b1, "R8");
    drive(10'h0F0, 1'b1, "R8");
    // R9: back to back
    preamble(1'b1, "R9");
    drive(10'h200, 1'b1, "R9");
    preamble(1'b1, "R9");
    drive(10'h2AC, 1'b1, "R9");
    drive(10'h1E0, 1'b1, "R9");
    // flush
    for (int i = 0; i < PD + 2; i++) drive(10'h040, 1'b1, "R2");
    mon_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule